// File: doc/BRIEF.md
# Serial Flash Command Acceptance and Write-Protection Gate

This block sits at the front of a small two-sector serial flash slave. It samples SPI mode 0 traffic (data taken on the rising edge of the serial clock while chip select is low), assembles bytes and captures the opcode, a 24-bit address and the first argument byte. It keeps the write enable latch, the status bits that set the protected region, the status-lock bit, a deep power-down flag and a power-up inhibit timer.

When chip select rises, the gate decides whether the frame that just ended may take effect. A modifying instruction is accepted only if four conditions hold: the clock count is a nonzero multiple of eight, the enable latch is set, the power-up timer has expired and the device is awake. The protection rules are checked as well. An accepted modifying instruction produces a one-cycle execute strobe carrying the opcode and address, and this strobe stands in for the whole busy period. The memory array and the read data paths lie elsewhere.

The signals `sck`, `csN` and `mosi` are oversampled by `clk`. Each SPI clock phase must last at least one `clk` cycle.

Top module: `spiWpGate`

## Requirements
- R1: PP (02h), SE (D8h), BE (C7h) and WRSR (01h) take effect only if the SCK rising edges counted while `csN` was low form a nonzero multiple of eight. PP also needs at least 5 bytes, SE at least 4 and WRSR at least 2. A frame that fails these tests is discarded with no state change.
- R2: A modifying instruction is discarded unless the enable latch (status bit 1) is set. WREN (06h) sets the latch.
- R3: The enable latch is cleared by reset, by WRDI (04h) and by every executed modifying instruction. A rejected instruction leaves the latch unchanged.
- R4: Status bits 3:2 hold the protect field. With the value 00, PP, SE and BE to either sector are accepted.
- R5: BE is accepted only when the protect field is 00.
- R6: With the protect field at 01, PP and SE are still accepted to both sectors. With 10 or 11 (status bit 3 set), PP and SE are rejected for both sectors. Address bit 15 selects the sector.
- R7: Status bit 7 is the lock bit. When it is 1 and `wpN` is low, WRSR is rejected and bits 7, 3 and 2 and the enable latch keep their values. With `wpN` high, WRSR writes bits 7, 3 and 2 from the matching bits of the argument byte.
- R8: DP (B9h) sets `deepPd`. While `deepPd` is set, every frame is ignored except RES (ABh), which clears it.
- R9: For `PUW_CYCLES` clock cycles after reset, `powerUpBusy` is high and every modifying instruction is rejected. WREN is still accepted during this time.
- R10: An accepted modifying instruction raises `execValid` for exactly one cycle, in the second `clk` cycle after `csN` is seen high. `execOp` carries the opcode and `execAddr` the three address bytes.
- R11: After reset, `statusOut` is 00h, `execValid` and `deepPd` are low and `powerUpBusy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| csN | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data into the slave |
| wpN | input | 1 | Write-protect pin, active low |
| execValid | output | 1 | One-cycle strobe for an accepted modifying instruction |
| execOp | output | 8 | Opcode of the accepted instruction |
| execAddr | output | 24 | Address bytes of the accepted instruction |
| statusOut | output | 8 | Status: bit 7 lock, bits 3:2 protect field, bit 1 enable latch |
| deepPd | output | 1 | Deep power-down state |
| powerUpBusy | output | 1 | Power-up inhibit timer still running |

## Verification
The assertions check on every cycle that each execute strobe follows a set enable latch, a quiet timer and an awake device. They also check that the strobe lasts one cycle, that the latch is clear as the strobe appears, and that bulk erase and sector operations respect the protect field. A further assertion checks that the locked status bits stay stable while hardware protection holds. Only the bench scenarios show the discarding of misaligned frames, the exact status value after each accepted write, the wake-up on RES and the opcode and address carried by each strobe.

// File: rtl/spiWpPkg.sv
package spiWpPkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_B    = 3;
  localparam int ADDR_W    = ADDR_B * BYTE_W;
  localparam int FRAME_CNT_W = 4;

  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_PP   = 8'h02;
  localparam logic [BYTE_W-1:0] OP_SE   = 8'hD8;
  localparam logic [BYTE_W-1:0] OP_BE   = 8'hC7;
  localparam logic [BYTE_W-1:0] OP_DP   = 8'hB9;
  localparam logic [BYTE_W-1:0] OP_RES  = 8'hAB;

  // minimum byte counts, opcode included
  localparam logic [FRAME_CNT_W-1:0] MIN_WRSR = 4'd2;
  localparam logic [FRAME_CNT_W-1:0] MIN_SE   = 4'd1 + 4'(ADDR_B);
  localparam logic [FRAME_CNT_W-1:0] MIN_PP   = 4'd2 + 4'(ADDR_B);

  // datapath -> control: summary of the frame being closed
  typedef struct packed {
    logic                   frameEnd;
    logic                   aligned;
    logic [FRAME_CNT_W-1:0] byteCnt;
    logic [BYTE_W-1:0]      opcode;
    logic [2:0]             statusWr; // {lock, protect[1:0]} from argument byte
  } frameInfo_t;

  // control -> datapath strobes
  typedef struct packed {
    logic fire;
  } ctrlStrobe_t;
endpackage

// File: rtl/spiWpFrame.sv
module spiWpFrame
  import spiWpPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  ctrlStrobe_t       strobe,
  output frameInfo_t        info,
  output logic              execValid,
  output logic [BYTE_W-1:0] execOp,
  output logic [ADDR_W-1:0] execAddr
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [FRAME_CNT_W-1:0] CNT_MAX = '1;

  logic                   sckPrev, csPrev;
  logic                   sckRise;
  logic [BIT_W-1:0]       bitPos;
  logic [FRAME_CNT_W-1:0] byteCnt;
  logic [BYTE_W-2:0]      shiftReg;
  logic [BYTE_W-1:0]      newByte;
  logic [BYTE_W-1:0]      opcode;
  logic [ADDR_W-1:0]      addr;

  assign sckRise = sck & ~sckPrev & ~csN;
  assign newByte = {shiftReg, mosi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sck;
      csPrev  <= csN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos   <= '0;
      byteCnt  <= '0;
      shiftReg <= '0;
      opcode   <= '0;
      addr     <= '0;
    end else if (csN) begin
      bitPos  <= '0;
      byteCnt <= '0;
    end else if (sckRise) begin
      bitPos <= bitPos + 1'b1;
      if (bitPos == BIT_W'(BYTE_W - 1)) begin
        if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
        if (byteCnt == '0) opcode <= newByte;
        for (int k = 1; k <= ADDR_B; k++) begin
          if (byteCnt == FRAME_CNT_W'(k))
            addr[(ADDR_B - k) * BYTE_W +: BYTE_W] <= newByte;
        end
      end else begin
        shiftReg <= newByte[BYTE_W-2:0];
      end
    end
  end

  always_comb begin
    info.frameEnd = csN & ~csPrev;
    info.aligned  = (bitPos == '0) && (byteCnt != '0);
    info.byteCnt  = byteCnt;
    info.opcode   = opcode;
    info.statusWr = {addr[ADDR_W-1], addr[ADDR_W-5:ADDR_W-6]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execValid <= 1'b0;
      execOp    <= '0;
      execAddr  <= '0;
    end else begin
      execValid <= strobe.fire;
      if (strobe.fire) begin
        execOp   <= opcode;
        execAddr <= addr;
      end
    end
  end
endmodule

// File: rtl/spiWpCtrl.sv
module spiWpCtrl
  import spiWpPkg::*;
#(
  parameter int PUW_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  frameInfo_t        info,
  output ctrlStrobe_t       strobe,
  output logic [BYTE_W-1:0] statusOut,
  output logic              deepPd,
  output logic              powerUpBusy
);
  localparam int PUW_W = $clog2(PUW_CYCLES + 1);

  logic             wel, lockBit;
  logic [1:0]       protect;
  logic [PUW_W-1:0] puwCnt;
  logic             hwLock, cmdOk, modBase;
  logic             fire, setWel, clrWel, wrStatus, enterDp, exitDp;

  assign powerUpBusy = (puwCnt != '0);
  assign hwLock      = lockBit & ~wpN;
  assign cmdOk       = info.frameEnd & info.aligned;
  assign modBase     = cmdOk & wel & ~powerUpBusy & ~deepPd;

  always_comb begin
    fire     = 1'b0;
    setWel   = 1'b0;
    clrWel   = 1'b0;
    wrStatus = 1'b0;
    enterDp  = 1'b0;
    exitDp   = 1'b0;
    if (cmdOk) begin
      if (deepPd) begin
        exitDp = (info.opcode == OP_RES);
      end else begin
        unique case (info.opcode)
          OP_WREN: setWel = 1'b1;
          OP_WRDI: clrWel = 1'b1;
          OP_DP:   enterDp = 1'b1;
          OP_WRSR: begin
            fire     = modBase && (info.byteCnt >= MIN_WRSR) && !hwLock;
            wrStatus = fire;
          end
          OP_PP:   fire = modBase && (info.byteCnt >= MIN_PP) && !protect[1];
          OP_SE:   fire = modBase && (info.byteCnt >= MIN_SE) && !protect[1];
          OP_BE:   fire = modBase && (protect == 2'b00);
          default: ;
        endcase
      end
    end
    if (fire) clrWel = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel     <= 1'b0;
      lockBit <= 1'b0;
      protect <= 2'b00;
      deepPd  <= 1'b0;
      puwCnt  <= PUW_W'(PUW_CYCLES);
    end else begin
      if (powerUpBusy) puwCnt <= puwCnt - 1'b1;
      if (clrWel)      wel <= 1'b0;
      else if (setWel) wel <= 1'b1;
      if (wrStatus) begin
        lockBit <= info.statusWr[2];
        protect <= info.statusWr[1:0];
      end
      if (enterDp)     deepPd <= 1'b1;
      else if (exitDp) deepPd <= 1'b0;
    end
  end

  assign strobe.fire = fire;
  assign statusOut   = {lockBit, 3'b000, protect, wel, 1'b0};
endmodule

// File: rtl/spiWpGate.sv
module spiWpGate
  import spiWpPkg::*;
#(
  parameter int PUW_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic        mosi,
  input  logic        wpN,
  output logic        execValid,
  output logic [7:0]  execOp,
  output logic [23:0] execAddr,
  output logic [7:0]  statusOut,
  output logic        deepPd,
  output logic        powerUpBusy
);
  frameInfo_t  info;
  ctrlStrobe_t strobe;

  spiWpFrame frame_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .strobe(strobe), .info(info),
    .execValid(execValid), .execOp(execOp), .execAddr(execAddr)
  );

  spiWpCtrl #(.PUW_CYCLES(PUW_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wpN(wpN), .info(info), .strobe(strobe),
    .statusOut(statusOut), .deepPd(deepPd), .powerUpBusy(powerUpBusy)
  );
endmodule

// File: rtl/spiWpGate_chk.sv
module spiWpGate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wpN,
  input logic        execValid,
  input logic [7:0]  execOp,
  input logic [7:0]  statusOut,
  input logic        deepPd,
  input logic        powerUpBusy
);
  // R2: a strobe is only issued when the latch was set the cycle before
  p_exec_needs_wel_r2: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> $past(statusOut[1]));

  // R3: the latch is already clear when the strobe appears
  p_wel_clear_on_exec_r3: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> !statusOut[1]);

  // R5: bulk erase only from an unprotected status
  p_be_unprotected_r5: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && execOp == 8'hC7) |-> ($past(statusOut[3:2]) == 2'b00));

  // R6: program and sector erase never with the upper protect bit set
  p_pp_se_protect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && (execOp == 8'h02 || execOp == 8'hD8)) |-> !$past(statusOut[3]));

  // R7: locked status bits hold while hardware protection applies
  p_hw_lock_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[7] && !wpN) |=> ($stable(statusOut[7]) && $stable(statusOut[3:2])));

  // R8: nothing executes from deep power-down
  p_deep_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(deepPd) |-> !execValid);

  // R9: nothing executes while the power-up timer runs
  p_powerup_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(powerUpBusy) |-> !execValid);

  // R10: the strobe lasts a single cycle
  p_exec_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    execValid |=> !execValid);
endmodule

bind spiWpGate spiWpGate_chk chk_i (
  .clk(clk), .rstN(rstN), .wpN(wpN), .execValid(execValid), .execOp(execOp),
  .statusOut(statusOut), .deepPd(deepPd), .powerUpBusy(powerUpBusy)
);

// File: tb/spiWpGate_tb_top.sv
`timescale 1ns/1ps
module spiWpGate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, sck = 1'b0, mosi = 1'b0, wpN = 1'b1;
  logic        execValid, deepPd, powerUpBusy;
  logic [7:0]  execOp, statusOut;
  logic [23:0] execAddr;
  int          checks = 0, fails = 0;
  logic        seenExec;

  always #10 clk = ~clk;

  spiWpGate #(.PUW_CYCLES(64)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .wpN(wpN),
    .execValid(execValid), .execOp(execOp), .execAddr(execAddr),
    .statusOut(statusOut), .deepPd(deepPd), .powerUpBusy(powerUpBusy)
  );

  // {op[8], args[32], bits[8], wp, expExec, expStatus[8], expDp}
  localparam int NV = 25;
  localparam logic [58:0] VECS [NV] = '{
    {8'hC7, 32'h00000000, 8'd8,  1'b1, 1'b1, 8'h00, 1'b0}, // R4 R5 BE unprotected
    {8'h02, 32'h00800055, 8'd40, 1'b1, 1'b0, 8'h00, 1'b0}, // R2 PP without latch
    {8'h06, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h02, 1'b0}, // R2 WREN
    {8'h02, 32'h00800055, 8'd39, 1'b1, 1'b0, 8'h02, 1'b0}, // R1 misaligned PP
    {8'h02, 32'h00800055, 8'd40, 1'b1, 1'b1, 8'h00, 1'b0}, // R4 R10 PP sector 1
    {8'h06, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h02, 1'b0},
    {8'h04, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h00, 1'b0}, // R3 WRDI
    {8'h06, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h02, 1'b0},
    {8'h01, 32'h04000000, 8'd16, 1'b1, 1'b1, 8'h04, 1'b0}, // R7 WRSR protect=01
    {8'h06, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h06, 1'b0},
    {8'hC7, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h06, 1'b0}, // R5 BE blocked
    {8'hD8, 32'h00000000, 8'd32, 1'b1, 1'b1, 8'h04, 1'b0}, // R6 SE allowed at 01
    {8'h06, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h06, 1'b0},
    {8'h01, 32'h88000000, 8'd16, 1'b1, 1'b1, 8'h88, 1'b0}, // R7 set lock, protect=10
    {8'h06, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h8A, 1'b0},
    {8'hD8, 32'h00800000, 8'd32, 1'b1, 1'b0, 8'h8A, 1'b0}, // R6 SE blocked
    {8'h02, 32'h00800055, 8'd40, 1'b1, 1'b0, 8'h8A, 1'b0}, // R6 PP blocked
    {8'h01, 32'h00000000, 8'd16, 1'b0, 1'b0, 8'h8A, 1'b0}, // R7 hw lock holds
    {8'h01, 32'h00000000, 8'd16, 1'b1, 1'b1, 8'h00, 1'b0}, // R7 pin released
    {8'h06, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h02, 1'b0},
    {8'hB9, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h02, 1'b1}, // R8 enter
    {8'h02, 32'h00800055, 8'd40, 1'b1, 1'b0, 8'h02, 1'b1}, // R8 PP ignored
    {8'h04, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h02, 1'b1}, // R8 WRDI ignored
    {8'hAB, 32'h00000000, 8'd8,  1'b1, 1'b0, 8'h02, 1'b0}, // R8 RES wakes
    {8'h02, 32'h00800055, 8'd40, 1'b1, 1'b1, 8'h00, 1'b0}  // R10 PP after wake
  };

  task automatic checkEq(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // sends n bits of data MSB first, then samples one cycle after csN rises
  task automatic sendFrame(input logic [39:0] data, input int n, input logic wp);
    @(negedge clk);
    wpN = wp; csN = 1'b0; sck = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mosi = data[39-i]; sck = 1'b0;
      @(negedge clk); sck = 1'b1;
    end
    @(negedge clk); sck = 1'b0;
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
    seenExec = execValid;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checkEq("R11 status at reset", 32'(statusOut), 32'h00);
    checkEq("R11 exec at reset", 32'(execValid), 0);
    checkEq("R11 deepPd at reset", 32'(deepPd), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R11 R9 powerUpBusy after reset", 32'(powerUpBusy), 1);

    // R9 WREN accepted while timer runs, BE rejected
    sendFrame({8'h06, 32'h0}, 8, 1'b1);
    checkEq("R9 WREN during timer", 32'(statusOut), 32'h02);
    sendFrame({8'hC7, 32'h0}, 8, 1'b1);
    checkEq("R9 BE during timer exec", 32'(seenExec), 0);
    checkEq("R9 BE during timer status", 32'(statusOut), 32'h02);
    for (int w = 0; w < 200 && powerUpBusy; w++) @(negedge clk);
    checkEq("R9 timer expires", 32'(powerUpBusy), 0);

    for (int v = 0; v < NV; v++) begin
      sendFrame(VECS[v][58:19], int'(VECS[v][18:11]), VECS[v][10]);
      checkEq($sformatf("vec %0d exec (R1-R10 table)", v), 32'(seenExec), 32'(VECS[v][9]));
      checkEq($sformatf("vec %0d status", v), 32'(statusOut), 32'(VECS[v][8:1]));
      checkEq($sformatf("vec %0d deepPd R8", v), 32'(deepPd), 32'(VECS[v][0]));
      if (VECS[v][9]) begin
        checkEq($sformatf("vec %0d R10 execOp", v), 32'(execOp), 32'(VECS[v][58:51]));
        if (VECS[v][58:51] == 8'h02 || VECS[v][58:51] == 8'hD8)
          checkEq($sformatf("vec %0d R10 execAddr", v), 32'(execAddr), 32'(VECS[v][50:27]));
        @(negedge clk);
        checkEq($sformatf("vec %0d R10 strobe ends", v), 32'(execValid), 0);
      end
    end

    // R1 WREN with 9 clocks is discarded
    sendFrame({8'h06, 32'h0}, 9, 1'b1);
    checkEq("R1 misaligned WREN", 32'(statusOut), 32'h00);
    // R1 SE short of address bytes
    sendFrame({8'h06, 32'h0}, 8, 1'b1);
    sendFrame({8'hD8, 32'h0}, 24, 1'b1);
    checkEq("R1 short SE exec", 32'(seenExec), 0);
    checkEq("R1 short SE latch kept R3", 32'(statusOut), 32'h02);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule